// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early-Warning Threshold

This block is a watchdog timer on a simple register bus. A down-counter of `W` bits runs while the timer is enabled and while the tick qualifier is high. When the count reaches a programmable nonzero threshold, an early-warning flag is raised. When the count reaches zero, a timeout flag is raised. Both flags are sticky. They drive the two interrupt outputs directly and are cleared through a dedicated clear port that takes a two-bit mask.

Software keeps the timer alive by writing a new tick count into the count register. That register, the threshold register and the enable register are all guarded by a lock. A correct 32-bit key must be written to the key offset immediately before each guarded write. The unlock is used up by one guarded write. Any other value written to the key offset drops it.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the timer is disabled, the count reads 0xFFFFFFFF, the threshold reads 0, both flags and both interrupt outputs are low, and the lock is closed.
- R2: A write of 0xF1D0DEAD to offset 0xC opens the lock. A write of any other value to offset 0xC closes it.
- R3: Writes to offsets 0x0, 0x4 and 0x8 are accepted only while the lock is open, and every such write closes the lock. Writes to the other offsets (those not a multiple of 4) change nothing, leave the lock as it is, and read back as 0.
- R4: An accepted write to offset 0x0 loads the count with the written value, except that 0 loads as 1. Reading offset 0x0 returns the ticks remaining, and reading offset 0x4 returns the threshold.
- R5: An accepted write to offset 0x8 sets the enable from data bit 0, and the enable reads back at bit 0. While enabled with the tick qualifier high, the count drops by one per clock and holds at 0. A load in the same cycle wins over the decrement.
- R6: The threshold flag is set on the clock edge after a cycle in which the timer is enabled and the count equals a nonzero threshold. It is set at most once per count load.
- R7: With the threshold at 0 the threshold flag is never set.
- R8: The timeout flag is set on the same clock edge on which a decrement takes the count from 1 to 0.
- R9: Each flag stays set until a clear pulse carries its mask bit: bit 8 for threshold, bit 9 for timeout. A new set in the same cycle wins over the clear. The interrupt outputs equal the flags, and offset 0xC reads the threshold flag at bit 8 and the timeout flag at bit 9.
- R10: While the tick qualifier is low, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count qualifier: decrement only when high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for bus_addr (combinational) |
| clr_pulse | input | 1 | Flag clear strobe |
| clr_mask | input | 2 (bits 9:8) | Bit 8 clears the threshold flag, bit 9 clears the timeout flag |
| irq_thr | output | 1 | Early-warning (threshold) interrupt |
| irq_tmo | output | 1 | Timeout interrupt |

## Verification
The lock is exercised with unkeyed writes, a wrong key, a second write after a single unlock, and an unmapped write placed between the key and a guarded write. Together these separate a lock that is single-use from one that stays open, and from one that is disturbed by stray writes. The countdown is run with the tick qualifier held high and also gated low, with reloads during the run and with a zero load. These show that the decrement, its priority against loads, and the clamp to 1 are applied as specified. The threshold is tried at zero, at a nonzero value, and again after a reload, to show that the early warning fires once per load and not at all when disabled. Clear pulses with each mask bit alone, and a clear on the very edge where the timeout flag sets, show which of set and clear wins.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int W = 32,
  parameter logic [W-1:0] UNLOCK_KEY = 32'hF1D0DEAD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         bus_we,
  input  logic [3:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         clr_pulse,
  input  logic [9:8]   clr_mask,
  output logic         irq_thr,
  output logic         irq_tmo
);
  localparam logic [3:0] OFS_CNT = 4'h0;
  localparam logic [3:0] OFS_THR = 4'h4;
  localparam logic [3:0] OFS_EN  = 4'h8;
  localparam logic [3:0] OFS_KEY = 4'hC;
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_q, thr_q;
  logic en_q, armed_q, done_q, thr_flag_q, tmo_flag_q;

  wire guarded = (bus_addr == OFS_CNT) || (bus_addr == OFS_THR) || (bus_addr == OFS_EN);
  wire wr_key  = bus_we && (bus_addr == OFS_KEY);
  wire wr_ok   = bus_we && armed_q && guarded;
  wire ld_cnt  = wr_ok && (bus_addr == OFS_CNT);
  wire ld_thr  = wr_ok && (bus_addr == OFS_THR);
  wire ld_en   = wr_ok && (bus_addr == OFS_EN);
  wire dec     = en_q && tick_en && (cnt_q != ZERO) && !ld_cnt;
  wire hit_thr = en_q && (thr_q != ZERO) && (cnt_q == thr_q) && !done_q;
  wire hit_tmo = dec && (cnt_q == ONE);
  wire [W-1:0] load_val = (bus_wdata == ZERO) ? ONE : bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '1;
      thr_q      <= '0;
      en_q       <= 1'b0;
      armed_q    <= 1'b0;
      done_q     <= 1'b0;
      thr_flag_q <= 1'b0;
      tmo_flag_q <= 1'b0;
    end else begin
      if (wr_key)
        armed_q <= (bus_wdata == UNLOCK_KEY);
      else if (bus_we && guarded)
        armed_q <= 1'b0;

      if (ld_cnt)   cnt_q <= load_val;
      else if (dec) cnt_q <= cnt_q - ONE;

      if (ld_thr) thr_q <= bus_wdata;
      if (ld_en)  en_q  <= bus_wdata[0];

      if (ld_cnt)       done_q <= 1'b0;
      else if (hit_thr) done_q <= 1'b1;

      thr_flag_q <= hit_thr | (thr_flag_q & ~(clr_pulse & clr_mask[8]));
      tmo_flag_q <= hit_tmo | (tmo_flag_q & ~(clr_pulse & clr_mask[9]));
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CNT: bus_rdata = cnt_q;
      OFS_THR: bus_rdata = thr_q;
      OFS_EN:  bus_rdata[0] = en_q;
      OFS_KEY: begin
        bus_rdata[8] = thr_flag_q;
        bus_rdata[9] = tmo_flag_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign irq_thr = thr_flag_q;
  assign irq_tmo = tmo_flag_q;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic         bus_we,
  input logic [3:0]   bus_addr,
  input logic         clr_pulse,
  input logic [9:8]   clr_mask,
  input logic         irq_thr,
  input logic         irq_tmo,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] thr_q,
  input logic         en_q,
  input logic         armed_q
);
  wire guarded = bus_we && (bus_addr == 4'h0 || bus_addr == 4'h4 || bus_addr == 4'h8);

  a_r3_lock_single_use: assert property (@(posedge clk) disable iff (!rst_n)
    guarded |=> !armed_q);

  a_r3_locked_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'h8 && !armed_q) |=> (en_q == $past(en_q)));

  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick_en && cnt_q != '0 && !(bus_we && armed_q && bus_addr == 4'h0))
      |=> (cnt_q == $past(cnt_q) - W'(1)));

  a_r5_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !(bus_we && armed_q && bus_addr == 4'h0)) |=> (cnt_q == '0));

  a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !(bus_we && armed_q && bus_addr == 4'h0)) |=> $stable(cnt_q));

  a_r7_zero_threshold_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == '0 && !irq_thr) |=> !irq_thr);

  a_r8_timeout_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tmo) |-> (cnt_q == '0));

  a_r9_thr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && clr_mask[8] && !en_q) |=> !irq_thr);
endmodule

bind keyed_wdt keyed_wdt_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .clr_pulse(clr_pulse), .clr_mask(clr_mask),
  .irq_thr(irq_thr), .irq_tmo(irq_tmo), .cnt_q(cnt_q), .thr_q(thr_q),
  .en_q(en_q), .armed_q(armed_q)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'hF1D0DEAD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        clr_pulse = 1'b0;
  logic [9:8]  clr_mask = 2'b00;
  logic        irq_thr, irq_tmo;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  string tag = "R1";

  keyed_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clr_pulse(clr_pulse), .clr_mask(clr_mask),
    .irq_thr(irq_thr), .irq_tmo(irq_tmo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  longint m_cnt, m_thr;
  bit m_en, m_open, m_done, m_ft, m_fo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 64'hFFFF_FFFF; m_thr = 0; m_en = 0; m_open = 0;
      m_done = 0; m_ft = 0; m_fo = 0;
    end else begin
      bit prot, take, load, ev_t, ev_o;
      longint nc;
      prot = bus_addr inside {4'h0, 4'h4, 4'h8};
      take = bus_we && m_open && prot;
      load = take && bus_addr == 4'h0;
      ev_t = m_en && m_thr != 0 && m_cnt == m_thr && !m_done;
      ev_o = m_en && tick_en && m_cnt == 1 && !load;
      nc = m_cnt;
      if (load) nc = (bus_wdata == 0) ? 1 : longint'(bus_wdata);
      else if (m_en && tick_en && m_cnt > 0) nc = m_cnt - 1;
      if (take && bus_addr == 4'h4) m_thr = longint'(bus_wdata);
      if (take && bus_addr == 4'h8) m_en = bus_wdata[0];
      if (bus_we && bus_addr == 4'hC) m_open = (bus_wdata == KEY);
      else if (bus_we && prot) m_open = 0;
      if (load) m_done = 0; else if (ev_t) m_done = 1;
      m_ft = ev_t || (m_ft && !(clr_pulse && clr_mask[8]));
      m_fo = ev_o || (m_fo && !(clr_pulse && clr_mask[9]));
      m_cnt = nc;
    end
  end

  function automatic logic [31:0] model_read(logic [3:0] a);
    case (a)
      4'h0: return m_cnt[31:0];
      4'h4: return m_thr[31:0];
      4'h8: return {31'b0, m_en};
      4'hC: return {22'b0, m_fo, m_ft, 8'b0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic compare();
    logic [31:0] er;
    er = model_read(bus_addr);
    n_cmp++;
    if (bus_rdata !== er || irq_thr !== m_ft || irq_tmo !== m_fo) begin
      n_bad++;
      $display("FAIL %s cyc %0d addr %h: rdata=%h thr=%b tmo=%b expected rdata=%h thr=%b tmo=%b",
               tag, cycles, bus_addr, bus_rdata, irq_thr, irq_tmo, er, m_ft, m_fo);
    end
  endtask

  // one clock with given bus activity; outputs compared at the next falling edge
  task automatic step(bit we, logic [3:0] a, logic [31:0] d);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    cycles++;
    compare();
    bus_we = 0; clr_pulse = 0; clr_mask = 2'b00;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 4'(4 * (i % 4)), 32'h0);
  endtask

  task automatic kwr(logic [3:0] a, logic [31:0] d);
    step(1, 4'hC, KEY);
    step(1, a, d);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    tag = "R1"; compare(); idle(4);
    tag = "R3"; step(1, 4'h0, 32'd20); idle(4);
    tag = "R4"; kwr(4'h0, 32'd20); idle(4);
    tag = "R3"; step(1, 4'h4, 32'd5); idle(4);
    tag = "R2"; step(1, 4'hC, 32'h1234_5678); step(1, 4'h4, 32'd5); idle(4);
    tag = "R2"; step(1, 4'hC, KEY); step(1, 4'hC, 32'h0); step(1, 4'h8, 32'd1); idle(4);
    tag = "R4"; kwr(4'h4, 32'd5); idle(4);
    tag = "R3"; step(1, 4'hC, KEY); step(1, 4'h2, 32'hFFFF); step(1, 4'h8, 32'd1);
    tag = "R5"; idle(8);
    tag = "R10"; tick_en = 0; idle(6); tick_en = 1;
    tag = "R6"; idle(10);
    tag = "R8"; idle(6);
    tag = "R9"; clr_pulse = 1; clr_mask = 2'b01; step(0, 4'hC, 0); idle(3);
    clr_pulse = 1; clr_mask = 2'b10; step(0, 4'hC, 0); idle(3);
    tag = "R4"; kwr(4'h0, 32'd0); idle(4);
    tag = "R9"; clr_pulse = 1; clr_mask = 2'b11; step(0, 4'hC, 0);
    kwr(4'h0, 32'd3); step(0, 4'hC, 0);
    clr_pulse = 1; clr_mask = 2'b10; step(0, 4'hC, 0);
    clr_pulse = 1; clr_mask = 2'b10; step(0, 4'hC, 0); idle(3);
    tag = "R7"; clr_pulse = 1; clr_mask = 2'b11; step(0, 4'hC, 0);
    kwr(4'h4, 32'd0); kwr(4'h0, 32'd12); idle(16);
    tag = "R6"; clr_pulse = 1; clr_mask = 2'b11; step(0, 4'hC, 0);
    kwr(4'h4, 32'd3); kwr(4'h0, 32'd6); idle(5);
    clr_pulse = 1; clr_mask = 2'b01; step(0, 4'hC, 0);
    kwr(4'h0, 32'd6); idle(8);
    tag = "R5"; kwr(4'h0, 32'd40); idle(3); kwr(4'h0, 32'd9); idle(3);
    kwr(4'h8, 32'd0); idle(5);
    tag = "R4"; kwr(4'h0, 32'hFFFF_FFFF); idle(4);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule